// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects up to sixty maskable interrupt request lines and decides which one a processor should service next. A rising edge on any line latches a pending flag for that channel. A small register port sets an enable bit and a 4-bit urgency value for each channel. A smaller urgency value means a more urgent request. The controller offers the best enabled pending channel to the core as a vector number together with its urgency, and it keeps track of the handler that is running.

The core accepts an offer with an acknowledge pulse. A fixed entry window of configurable length follows. If a more urgent request arrives during that window, it takes the place of the one being entered, and the displaced channel becomes pending again. When the window closes, the entered channel becomes the running handler. A more urgent request can preempt a running handler, and the interrupted context is saved on a stack of urgencies. When a handler signals its exit, the controller checks the waiting requests. If one beats the context that would be restored, the controller moves straight into a new entry window for it. Otherwise it pops the stack and resumes the interrupted handler.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset no channel is pending or enabled, every urgency reads 0, and `req_valid`, `entry_busy`, `run_valid`, `tail_chain` and `nest_depth` are all 0.
- R2: A write to address n below NUM_IRQ sets the channel's enable from data bit 4 and its urgency from data bits 3:0. A read of address n returns {pending (bit 5), enable (bit 4), urgency (bits 3:0)}. Addresses at or above NUM_IRQ ignore writes and read as 0.
- R3: A rising edge on `irq_in[n]` sets channel n's pending flag in the next cycle, whether or not the channel is enabled. The flag stays set until that channel is taken into an entry window.
- R4: The offered channel is the enabled pending channel with the smallest urgency value, and the lowest channel number wins a tie. A disabled pending channel is never offered.
- R5: `req_valid` is high only outside the entry window, and only when the candidate's urgency is strictly smaller than the running handler's urgency or no handler is running. An equal urgency does not preempt.
- R6: When `irq_ack` is high while `req_valid` is high, the offered channel's pending flag clears. `entry_busy` then stays high for exactly ENTRY_CYC cycles with `run_valid` low. After that the channel is running, with `run_vector` and `run_prio` showing it.
- R7: During the entry window, an enabled pending request whose urgency is strictly smaller than the channel being entered replaces it on `entry_vector`. The replaced channel becomes pending again, and the window keeps its original end.
- R8: On `irq_exit` with no waiting request strictly more urgent than the saved context, the stack pops. The saved handler runs again and `nest_depth` drops by one. With an empty stack, `run_valid` goes low.
- R9: On `irq_exit`, if a waiting request is strictly more urgent than the saved context (or the stack is empty), that channel enters a new entry window at once. `tail_chain` pulses for one cycle, `req_valid` stays low and `nest_depth` is unchanged.
- R10: Accepting a preempting request while a handler runs pushes that handler, and `nest_depth` rises by one.
- R11: `irq_ack` has no effect while `req_valid` is low, and `irq_exit` has no effect while `run_valid` is low. When both arrive together while a handler runs, the exit is taken and the acknowledge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_IRQ | Request lines, latched on rising edge |
| irq_ack | input | 1 | Core accepts the offered vector |
| irq_exit | input | 1 | Running handler returns |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Channel number for read and write |
| reg_wdata | input | 5 | {enable, urgency} write data |
| reg_rdata | output | 6 | {pending, enable, urgency} read data |
| req_valid | output | 1 | A vector is offered to the core |
| req_vector | output | 6 | Offered channel number |
| req_prio | output | 4 | Offered channel urgency |
| entry_busy | output | 1 | Entry window in progress |
| entry_vector | output | 6 | Channel being entered |
| run_valid | output | 1 | A handler is running |
| run_vector | output | 6 | Running channel |
| run_prio | output | 4 | Running urgency |
| tail_chain | output | 1 | One-cycle pulse when an exit chains into a new entry |
| nest_depth | output | $clog2(STACK_DEPTH+1) | Number of saved preempted contexts |

## Verification
The assertions assume the core behaves politely. It raises `irq_ack` only when it has seen `req_valid`, and it raises `irq_exit` only while `run_valid` is high. It never pulses both in the same cycle. The stimulus holds to these rules: acknowledges and exits are driven for one cycle each, only after the bench has checked the offer or the running state. Request lines are pulsed for one cycle, so each pulse produces exactly one pending edge. Random rounds reprogram every channel and then drain all enabled pending requests through acknowledge and tail-chained exits.

// File: rtl/nest_irq_pkg.sv
package nest_irq_pkg;

    localparam int PRIO_W = 4;
    localparam int VEC_W  = 6;
    localparam int WDAT_W = PRIO_W + 1;
    localparam int RDAT_W = PRIO_W + 2;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [VEC_W-1:0]  vec_t;

    typedef struct packed {
        vec_t  vec;
        prio_t prio;
    } ctx_t;

    typedef enum logic {
        PH_OPEN  = 1'b0,
        PH_ENTRY = 1'b1
    } phase_e;

    function automatic logic prio_beats(prio_t a, prio_t b);
        return a < b;
    endfunction

endpackage

// File: rtl/nest_irq_cfg.sv
module nest_irq_cfg import nest_irq_pkg::*; #(
    parameter int NUM_IRQ = 60
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  vec_t                    addr,
    input  logic [WDAT_W-1:0]       wdata,
    output logic [NUM_IRQ-1:0]      en_o,
    output prio_t [NUM_IRQ-1:0]     prio_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_o   <= '0;
            prio_o <= '0;
        end else if (we && (int'(addr) < NUM_IRQ)) begin
            en_o[addr]   <= wdata[PRIO_W];
            prio_o[addr] <= wdata[PRIO_W-1:0];
        end
    end

endmodule

// File: rtl/nest_irq_pend.sv
module nest_irq_pend import nest_irq_pkg::*; #(
    parameter int NUM_IRQ = 60
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] req_in,
    input  logic               clr_en,
    input  vec_t               clr_idx,
    input  logic               set_en,
    input  vec_t               set_idx,
    output logic [NUM_IRQ-1:0] pend_o
);

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_chan
        logic prev_q;
        logic hit_clr;
        logic hit_set;

        assign hit_clr = clr_en && (clr_idx == VEC_W'(g));
        assign hit_set = set_en && (set_idx == VEC_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q    <= 1'b0;
                pend_o[g] <= 1'b0;
            end else begin
                prev_q    <= req_in[g];
                pend_o[g] <= (req_in[g] && !prev_q) || hit_set
                             || (pend_o[g] && !hit_clr);
            end
        end
    end

endmodule

// File: rtl/nest_irq_arb.sv
module nest_irq_arb import nest_irq_pkg::*; #(
    parameter int NUM_IRQ = 60
) (
    input  logic [NUM_IRQ-1:0]  pend,
    input  logic [NUM_IRQ-1:0]  en,
    input  prio_t [NUM_IRQ-1:0] prio,
    output logic                cand_v,
    output ctx_t                cand
);

    always_comb begin
        cand_v    = 1'b0;
        cand.vec  = '0;
        cand.prio = '1;
        // Strict compare keeps the lowest index on equal urgency.
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (pend[i] && en[i] && (!cand_v || prio_beats(prio[i], cand.prio))) begin
                cand_v    = 1'b1;
                cand.vec  = VEC_W'(i);
                cand.prio = prio[i];
            end
        end
    end

endmodule

// File: rtl/nest_irq_stack.sv
module nest_irq_stack import nest_irq_pkg::*; #(
    parameter int DEPTH = 16,
    localparam int DW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  ctx_t          din,
    output ctx_t          top,
    output logic [DW-1:0] depth,
    output logic          full,
    output logic          empty
);

    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    ctx_t mem [DEPTH];

    assign full  = (int'(depth) == DEPTH);
    assign empty = (depth == '0);
    assign top   = empty ? '0 : mem[IW'(depth - DW'(1))];

    always_ff @(posedge clk) begin
        if (push && !full) begin
            mem[IW'(depth)] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            depth <= '0;
        end else if (push && !full) begin
            depth <= depth + DW'(1);
        end else if (pop && !empty) begin
            depth <= depth - DW'(1);
        end
    end

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl import nest_irq_pkg::*; #(
    parameter int NUM_IRQ     = 60,
    parameter int ENTRY_CYC   = 12,
    parameter int STACK_DEPTH = 16
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_IRQ-1:0]               irq_in,
    input  logic                             irq_ack,
    input  logic                             irq_exit,
    input  logic                             reg_we,
    input  logic [VEC_W-1:0]                 reg_addr,
    input  logic [WDAT_W-1:0]                reg_wdata,
    output logic [RDAT_W-1:0]                reg_rdata,
    output logic                             req_valid,
    output logic [VEC_W-1:0]                 req_vector,
    output logic [PRIO_W-1:0]                req_prio,
    output logic                             entry_busy,
    output logic [VEC_W-1:0]                 entry_vector,
    output logic                             run_valid,
    output logic [VEC_W-1:0]                 run_vector,
    output logic [PRIO_W-1:0]                run_prio,
    output logic                             tail_chain,
    output logic [$clog2(STACK_DEPTH+1)-1:0] nest_depth
);

    localparam int CNT_W = $clog2(ENTRY_CYC + 1);

    logic [NUM_IRQ-1:0]  en;
    logic [NUM_IRQ-1:0]  pend;
    prio_t [NUM_IRQ-1:0] prio;

    logic   cand_v;
    ctx_t   cand;
    ctx_t   stk_top;
    logic   stk_full, stk_empty;
    logic   push, pop;
    logic   clr_en, set_en;
    vec_t   clr_idx, set_idx;

    phase_e             phase_q;
    logic [CNT_W-1:0]   cnt_q;
    ctx_t               ent_q;
    ctx_t               run_q;
    logic               run_v_q;
    logic               tail_q;

    logic take_ok, leave, accept, chain, late;

    nest_irq_cfg #(.NUM_IRQ(NUM_IRQ)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .en_o   (en),
        .prio_o (prio)
    );

    nest_irq_pend #(.NUM_IRQ(NUM_IRQ)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .req_in  (irq_in),
        .clr_en  (clr_en),
        .clr_idx (clr_idx),
        .set_en  (set_en),
        .set_idx (set_idx),
        .pend_o  (pend)
    );

    nest_irq_arb #(.NUM_IRQ(NUM_IRQ)) u_arb (
        .pend   (pend),
        .en     (en),
        .prio   (prio),
        .cand_v (cand_v),
        .cand   (cand)
    );

    nest_irq_stack #(.DEPTH(STACK_DEPTH)) u_stack (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .pop   (pop),
        .din   (run_q),
        .top   (stk_top),
        .depth (nest_depth),
        .full  (stk_full),
        .empty (stk_empty)
    );

    // Handshake decisions
    always_comb begin
        take_ok = cand_v && (!run_v_q || prio_beats(cand.prio, run_q.prio))
                  && !(run_v_q && stk_full);
        req_valid = (phase_q == PH_OPEN) && take_ok;
        leave  = (phase_q == PH_OPEN) && run_v_q && irq_exit;
        accept = req_valid && irq_ack && !leave;
        chain  = leave && cand_v && (stk_empty || prio_beats(cand.prio, stk_top.prio));
        late   = (phase_q == PH_ENTRY) && cand_v && prio_beats(cand.prio, ent_q.prio);

        clr_en  = accept || chain || late;
        clr_idx = cand.vec;
        set_en  = late;
        set_idx = ent_q.vec;

        push = accept && run_v_q;
        pop  = leave && !chain && !stk_empty;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_OPEN;
            cnt_q   <= '0;
            ent_q   <= '0;
            run_q   <= '0;
            run_v_q <= 1'b0;
            tail_q  <= 1'b0;
        end else begin
            tail_q <= chain;
            unique case (phase_q)
                PH_OPEN: begin
                    if (leave) begin
                        if (chain) begin
                            phase_q <= PH_ENTRY;
                            ent_q   <= cand;
                            cnt_q   <= CNT_W'(ENTRY_CYC - 1);
                            run_v_q <= 1'b0;
                        end else if (!stk_empty) begin
                            run_q   <= stk_top;
                            run_v_q <= 1'b1;
                        end else begin
                            run_v_q <= 1'b0;
                        end
                    end else if (accept) begin
                        phase_q <= PH_ENTRY;
                        ent_q   <= cand;
                        cnt_q   <= CNT_W'(ENTRY_CYC - 1);
                        run_v_q <= 1'b0;
                    end
                end
                PH_ENTRY: begin
                    if (late) begin
                        ent_q <= cand;
                    end
                    if (cnt_q == '0) begin
                        phase_q <= PH_OPEN;
                        run_q   <= late ? cand : ent_q;
                        run_v_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                default: phase_q <= PH_OPEN;
            endcase
        end
    end

    // Register read port
    always_comb begin
        reg_rdata = '0;
        if (int'(reg_addr) < NUM_IRQ) begin
            reg_rdata = {pend[reg_addr], en[reg_addr], prio[reg_addr]};
        end
    end

    assign req_vector   = cand.vec;
    assign req_prio     = cand.prio;
    assign entry_busy   = (phase_q == PH_ENTRY);
    assign entry_vector = ent_q.vec;
    assign run_valid    = run_v_q;
    assign run_vector   = run_q.vec;
    assign run_prio     = run_q.prio;
    assign tail_chain   = tail_q;

endmodule

// File: rtl/nest_irq_chk.sv
module nest_irq_chk import nest_irq_pkg::*; #(
    parameter int NUM_IRQ = 60,
    parameter int DEPTH_W = 5
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               irq_ack,
    input logic               irq_exit,
    input logic [VEC_W-1:0]   req_vector,
    input logic [PRIO_W-1:0]  req_prio,
    input logic               entry_busy,
    input logic               run_valid,
    input logic [PRIO_W-1:0]  run_prio,
    input logic               tail_chain,
    input logic [DEPTH_W-1:0] nest_depth
);

    AST_NO_REQ_IN_ENTRY: assert property (@(posedge clk) disable iff (rst)
        entry_busy |-> !req_valid); // R5

    AST_STRICT_PREEMPT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && run_valid) |-> (req_prio < run_prio)); // R5

    AST_NO_RUN_IN_ENTRY: assert property (@(posedge clk) disable iff (rst)
        entry_busy |-> !run_valid); // R6

    AST_ACK_OPENS_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (req_valid && irq_ack && !(irq_exit && run_valid)) |=> entry_busy); // R6

    AST_TAIL_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        tail_chain |-> entry_busy); // R9

    AST_TAIL_PULSE: assert property (@(posedge clk) disable iff (rst)
        tail_chain |=> !tail_chain); // R9

    AST_DEPTH_STEP: assert property (@(posedge clk) disable iff (rst)
        ((int'(nest_depth) - int'($past(nest_depth))) <= 1)
        && ((int'($past(nest_depth)) - int'(nest_depth)) <= 1)); // R10

    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
        (!req_valid && !entry_busy && !run_valid) |=> !entry_busy); // R11

    AST_VEC_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (int'(req_vector) < NUM_IRQ)); // R4

endmodule

bind nest_irq_ctrl nest_irq_chk #(
    .NUM_IRQ (NUM_IRQ),
    .DEPTH_W ($clog2(STACK_DEPTH+1))
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .irq_ack    (irq_ack),
    .irq_exit   (irq_exit),
    .req_vector (req_vector),
    .req_prio   (req_prio),
    .entry_busy (entry_busy),
    .run_valid  (run_valid),
    .run_prio   (run_prio),
    .tail_chain (tail_chain),
    .nest_depth (nest_depth)
);

// File: tb/nest_irq_ctrl_tb.sv
module nest_irq_ctrl_tb;

    localparam int N  = 60;
    localparam int EC = 12;
    localparam int SD = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0] irq_in = '0;
    logic irq_ack = 1'b0;
    logic irq_exit = 1'b0;
    logic reg_we = 1'b0;
    logic [5:0] reg_addr = '0;
    logic [4:0] reg_wdata = '0;
    logic [5:0] reg_rdata;
    logic req_valid;
    logic [5:0] req_vector;
    logic [3:0] req_prio;
    logic entry_busy;
    logic [5:0] entry_vector;
    logic run_valid;
    logic [5:0] run_vector;
    logic [3:0] run_prio;
    logic tail_chain;
    logic [$clog2(SD+1)-1:0] nest_depth;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    bit sh_en [N];
    int sh_prio [N];
    bit sh_pend [N];

    nest_irq_ctrl #(.NUM_IRQ(N), .ENTRY_CYC(EC), .STACK_DEPTH(SD)) u_dut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .irq_ack(irq_ack), .irq_exit(irq_exit),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_vector(req_vector), .req_prio(req_prio),
        .entry_busy(entry_busy), .entry_vector(entry_vector), .run_valid(run_valid),
        .run_vector(run_vector), .run_prio(run_prio), .tail_chain(tail_chain),
        .nest_depth(nest_depth)
    );

    always #5 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int ch, input bit e, input int p);
        reg_we = 1'b1;
        reg_addr = 6'(ch);
        reg_wdata = {e, 4'(p)};
        tick();
        reg_we = 1'b0;
        if (ch < N) begin
            sh_en[ch] = e;
            sh_prio[ch] = p;
        end
    endtask

    task automatic rdchk(input string tag, input int ch, input int exp);
        reg_addr = 6'(ch);
        #1;
        chk(tag, int'(reg_rdata), exp);
    endtask

    task automatic pulse(input logic [N-1:0] m);
        irq_in = m;
        tick();
        irq_in = '0;
        for (int i = 0; i < N; i++) if (m[i]) sh_pend[i] = 1'b1;
    endtask

    task automatic do_ack();
        irq_ack = 1'b1;
        tick();
        irq_ack = 1'b0;
    endtask

    task automatic do_exit();
        irq_exit = 1'b1;
        tick();
        irq_exit = 1'b0;
    endtask

    task automatic wait_win();
        repeat (EC) tick();
    endtask

    function automatic int best();
        int b = -1;
        for (int i = 0; i < N; i++)
            if (sh_pend[i] && sh_en[i] && (b < 0 || sh_prio[i] < sh_prio[b])) b = i;
        return b;
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            sh_en[i] = 0; sh_prio[i] = 0; sh_pend[i] = 0;
        end
        void'($urandom(32'h5eed_0042));
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1 reset state
        chk("R1 req_valid", int'(req_valid), 0);
        chk("R1 run_valid", int'(run_valid), 0);
        chk("R1 entry_busy", int'(entry_busy), 0);
        chk("R1 tail_chain", int'(tail_chain), 0);
        chk("R1 nest_depth", int'(nest_depth), 0);
        rdchk("R1 channel 5 register", 5, 0);

        // R2 register port
        wr(3, 1, 4); wr(10, 1, 4); wr(7, 0, 2); wr(20, 1, 1);
        wr(30, 1, 6); wr(40, 1, 3); wr(41, 1, 3);
        rdchk("R2 readback channel 3", 3, 'h14);
        rdchk("R2 readback channel 20", 20, 'h11);
        wr(63, 1, 5);
        rdchk("R2 out-of-range address", 63, 0);

        // R3 / R4 disabled channel latches but is not offered
        pulse(N'(1) << 7);
        chk("R4 disabled not offered", int'(req_valid), 0);
        rdchk("R3 pending on disabled channel", 7, 'h22);

        // R4 tie on urgency picks lowest index
        pulse((N'(1) << 3) | (N'(1) << 10));
        chk("R4 tie valid", int'(req_valid), 1);
        chk("R4 tie vector", int'(req_vector), 3);
        chk("R4 tie urgency", int'(req_prio), 4);
        repeat (3) tick();
        rdchk("R3 pending held", 3, 'h34);

        // R11 exit with nothing running
        do_exit();
        chk("R11 exit ignored busy", int'(entry_busy), 0);
        chk("R11 exit ignored run", int'(run_valid), 0);
        chk("R11 exit ignored depth", int'(nest_depth), 0);

        // R6 acknowledge
        do_ack();
        chk("R6 window open", int'(entry_busy), 1);
        chk("R6 entry vector", int'(entry_vector), 3);
        chk("R5 no offer in window", int'(req_valid), 0);
        rdchk("R6 pending cleared", 3, 'h14);

        // R7 late arrival inside the window
        for (int k = 0; k < EC; k++) begin
            if (k == 0) irq_in[20] = 1'b1;
            if (k == 1) irq_in = '0;
            if (k == 2) begin
                chk("R7 replaced vector", int'(entry_vector), 20);
                rdchk("R7 displaced re-pended", 3, 'h34);
            end
            if (k == EC - 1) chk("R7 window keeps end", int'(entry_busy), 1);
            tick();
        end
        chk("R7 running after window", int'(run_valid), 1);
        chk("R7 running vector", int'(run_vector), 20);
        chk("R6 running urgency", int'(run_prio), 1);
        chk("R5 equal-or-worse no offer", int'(req_valid), 0);

        // R9 tail chain with empty stack
        do_exit();
        chk("R9 tail pulse", int'(tail_chain), 1);
        chk("R9 window entered", int'(entry_busy), 1);
        chk("R9 chained vector", int'(entry_vector), 3);
        chk("R9 no offer", int'(req_valid), 0);
        tick();
        chk("R9 tail one cycle", int'(tail_chain), 0);
        repeat (EC - 1) tick();
        chk("R9 chained runs", int'(run_vector), 3);

        // R5 / R10 preemption
        pulse(N'(1) << 40);
        chk("R5 preempt offered", int'(req_valid), 1);
        chk("R5 preempt vector", int'(req_vector), 40);
        do_ack();
        chk("R10 depth after push", int'(nest_depth), 1);
        wait_win();
        chk("R10 preemptor runs", int'(run_vector), 40);

        // R5 equal urgency, then R9 chain with non-empty stack
        pulse(N'(1) << 41);
        chk("R5 equal urgency no preempt", int'(req_valid), 0);
        do_exit();
        chk("R9 chain over saved context", int'(tail_chain), 1);
        chk("R9 depth unchanged", int'(nest_depth), 1);
        chk("R9 chained vector 41", int'(entry_vector), 41);
        wait_win();
        chk("R9 41 runs", int'(run_vector), 41);

        // R8 pop restores saved handler
        pulse(N'(1) << 30);
        do_exit();
        chk("R8 no chain", int'(tail_chain), 0);
        chk("R8 restored valid", int'(run_valid), 1);
        chk("R8 restored vector", int'(run_vector), 3);
        chk("R8 restored urgency", int'(run_prio), 4);
        chk("R8 depth popped", int'(nest_depth), 0);
        chk("R5 restored blocks equal", int'(req_valid), 0);

        do_exit(); wait_win();
        chk("R9 drain to 10", int'(run_vector), 10);
        do_exit(); wait_win();
        chk("R9 drain to 30", int'(run_vector), 30);
        do_exit();
        chk("R8 empty exit idle", int'(run_valid), 0);
        chk("R8 empty exit no chain", int'(tail_chain), 0);

        // R11 ack without offer
        irq_ack = 1'b1;
        tick();
        irq_ack = 1'b0;
        chk("R11 ack ignored", int'(entry_busy), 0);

        for (int i = 0; i < N; i++) sh_pend[i] = 0;
        sh_pend[7] = 1;

        // Random rounds (R4 R6 R9)
        for (int r = 0; r < 16; r++) begin
            logic [N-1:0] m;
            int b;
            for (int ch = 0; ch < N; ch++) wr(ch, ($urandom % 4) != 0, int'($urandom % 16));
            m = N'({$urandom, $urandom}) & N'({$urandom, $urandom}) & N'({$urandom, $urandom});
            pulse(m);
            b = best();
            if (b < 0) begin
                chk("R4 random nothing offered", int'(req_valid), 0);
                continue;
            end
            chk("R4 random offer valid", int'(req_valid), 1);
            chk("R4 random offer vector", int'(req_vector), b);
            chk("R4 random offer urgency", int'(req_prio), sh_prio[b]);
            do_ack();
            sh_pend[b] = 0;
            wait_win();
            chk("R6 random running vector", int'(run_vector), b);
            for (int it = 0; it < N + 1; it++) begin
                do_exit();
                b = best();
                if (b < 0) begin
                    chk("R8 random drained", int'(run_valid), 0);
                    chk("R9 random no chain", int'(tail_chain), 0);
                    break;
                end
                chk("R9 random chain", int'(tail_chain), 1);
                sh_pend[b] = 0;
                wait_win();
                chk("R9 random chained vector", int'(run_vector), b);
                chk("R9 random chained urgency", int'(run_prio), sh_prio[b]);
            end
        end

        done = 1;
        summary();
        $finish;
    end

endmodule